// File: doc/BRIEF.md
# MMIO Byte-Order Swap Bridge

This block sits on the data path of a PCI-side bus interface unit. For every 32-bit access it decides whether the four byte lanes of the data are reversed on their way through. The decision depends on who issued the access, whether it is a memory-mapped register access, whether it targets one of the special registers, and a swap-enable flag. The byte-enable vector is reversed together with the data, so that partial writes still land in the correct lanes.

The swap-enable flag lives in a control register inside the bridge. That register is itself reached through an MMIO access. While the flag is clear, a host write to this register is byte-reversed like any other host MMIO word. A little-endian host therefore has to place the enable bit in the byte-reversed position for its first write. After that write, host MMIO words pass straight through.

The data path is combinational and ends in a single output register. Every access costs exactly one cycle, whether it is swapped or not.

Top module: `mmio_swap_bridge`

## Requirements
- R1: After reset the swap-enable flag is 0, `out_valid` is 0, and `out_data` and `out_be` are 0.
- R2: With the flag at 0, a host-side MMIO access (`in_src`=0, `in_mmio`=1, `in_special`=0) has its bytes reversed in both directions: output byte k (bits 8k+7..8k) equals input byte 3-k.
- R3: Whenever the data is byte-reversed, the byte enables are reversed as well: `out_be[k]` = `in_be[3-k]`. Otherwise they pass unchanged.
- R4: With the flag at 1, host-side MMIO data and byte enables pass through unchanged.
- R5: An MMIO access from the local processor (`in_src`=1) is never swapped, whatever the flag value.
- R6: A non-MMIO access (`in_mmio`=0) is never swapped, from either source and with either flag value.
- R7: An access with `in_special`=1 (configuration, I/O and DMA registers) is never swapped. It is also never treated as a control-register access.
- R8: A control-register write (`in_mmio`=1, `in_ctl_hit`=1, `in_special`=0, `in_write`=1) loads the flag from bit 0 of the word after the swap decision. While the flag is 0, a host must therefore set bit 24 to enable it. A host write with only bit 0 set leaves the flag at 0.
- R9: A control-register read returns the flag in bit 0 with all other bits 0, transformed by the same swap policy. A host read with the flag at 0 therefore sees the flag in bit 24.
- R10: A flag change applies from the access in the cycle after the control-register write. Back-to-back accesses see the new policy.
- R11: `out_valid` follows `in_valid` one cycle later. In a cycle without a valid input, `out_data` and `out_be` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Access present this cycle |
| in_src | input | 1 | Issuer: 0 = PCI host side, 1 = local processor |
| in_mmio | input | 1 | 1 = memory-mapped register access, 0 = ordinary memory traffic |
| in_special | input | 1 | 1 = configuration, I/O or DMA special register |
| in_ctl_hit | input | 1 | Access addresses the bridge control register |
| in_write | input | 1 | 1 = write, 0 = read |
| in_data | input | 32 | Write data, or read data returning from the register file |
| in_be | input | 4 | Byte enables, bit k covers byte lane k |
| out_valid | output | 1 | Registered result present |
| out_data | output | 32 | Swapped or passed-through data |
| out_be | output | 4 | Swapped or passed-through byte enables |

## Verification
The hardest situation to reach is the self-referencing enable write. The host's first control write is reversed by the very policy it is trying to switch off, and the next access must already use the new policy. The stimulus covers three cases: a host write with the bit in the naive position (bit 0), which must leave the flag clear; a write with the bit in the reversed position (bit 24); and an immediate back-to-back host access. The flag is read back through the control register from both sources, so its value is seen only at the ports.

// File: rtl/swp_pkg.sv
package swp_pkg;
   typedef enum logic {
      SRC_HOST  = 1'b0,
      SRC_LOCAL = 1'b1
   } swp_src_e;

   typedef struct packed {
      logic do_swap;
      logic ctl_wr;
      logic ctl_rd;
   } swp_dec_t;
endpackage

// File: rtl/swp_lane_rev.sv
module swp_lane_rev #(
   parameter int DATA_W = 32,
   parameter int LANE_W = 8,
   localparam int LANES = DATA_W / LANE_W
) (
   input  logic [DATA_W-1:0] d_in,
   input  logic [LANES-1:0]  be_in,
   output logic [DATA_W-1:0] d_rev,
   output logic [LANES-1:0]  be_rev
);
   initial begin
      assert (DATA_W % LANE_W == 0) else $error("DATA_W must be a multiple of LANE_W");
      assert (LANES >= 1) else $error("at least one lane required");
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign d_rev[g*LANE_W +: LANE_W] = d_in[(LANES-1-g)*LANE_W +: LANE_W];
      assign be_rev[g]                 = be_in[LANES-1-g];
   end
endmodule

// File: rtl/swp_policy.sv
module swp_policy
   import swp_pkg::*;
(
   input  logic     valid,
   input  swp_src_e src,
   input  logic     mmio,
   input  logic     special,
   input  logic     ctl_hit,
   input  logic     write,
   input  logic     flag,
   output swp_dec_t dec
);
   logic is_reg;
   logic is_ctl;

   always_comb begin
      is_reg      = mmio & ~special;
      is_ctl      = valid & is_reg & ctl_hit;
      dec.do_swap = is_reg & (src == SRC_HOST) & ~flag;
      dec.ctl_wr  = is_ctl & write;
      dec.ctl_rd  = is_ctl & ~write;
   end
endmodule

// File: rtl/swp_ctl_reg.sv
module swp_ctl_reg #(
   parameter int DATA_W = 32,
   parameter int SE_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_word,
   output logic              flag,
   output logic [DATA_W-1:0] rd_word
);
   initial begin
      assert (SE_BIT >= 0 && SE_BIT < DATA_W) else $error("SE_BIT outside the word");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag <= 1'b0;
      else if (wr_en) flag <= wr_word[SE_BIT];
   end

   always_comb begin
      rd_word         = '0;
      rd_word[SE_BIT] = flag;
   end

   // R8
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(flag));
endmodule

// File: rtl/mmio_swap_bridge.sv
module mmio_swap_bridge
   import swp_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LANE_W = 8,
   parameter int SE_BIT = 0,
   localparam int LANES = DATA_W / LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_src,
   input  logic              in_mmio,
   input  logic              in_special,
   input  logic              in_ctl_hit,
   input  logic              in_write,
   input  logic [DATA_W-1:0] in_data,
   input  logic [LANES-1:0]  in_be,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic [LANES-1:0]  out_be
);
   swp_dec_t          dec;
   logic              flag;
   logic [DATA_W-1:0] ctl_word;
   logic [DATA_W-1:0] sel_word;
   logic [DATA_W-1:0] rev_word;
   logic [LANES-1:0]  rev_be;
   logic [DATA_W-1:0] nxt_word;
   logic [LANES-1:0]  nxt_be;

   swp_policy u_policy (
      .valid   (in_valid),
      .src     (swp_src_e'(in_src)),
      .mmio    (in_mmio),
      .special (in_special),
      .ctl_hit (in_ctl_hit),
      .write   (in_write),
      .flag    (flag),
      .dec     (dec)
   );

   assign sel_word = dec.ctl_rd ? ctl_word : in_data;

   swp_lane_rev #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_rev (
      .d_in   (sel_word),
      .be_in  (in_be),
      .d_rev  (rev_word),
      .be_rev (rev_be)
   );

   assign nxt_word = dec.do_swap ? rev_word : sel_word;
   assign nxt_be   = dec.do_swap ? rev_be   : in_be;

   swp_ctl_reg #(.DATA_W(DATA_W), .SE_BIT(SE_BIT)) u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (dec.ctl_wr),
      .wr_word (nxt_word),
      .flag    (flag),
      .rd_word (ctl_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_be    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_data <= nxt_word;
            out_be   <= nxt_be;
         end
      end
   end

   // R11
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_data) && $stable(out_be)));

   // R6
   nonmmio_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_mmio) |=> (out_data == $past(in_data) && out_be == $past(in_be)));

   // R7
   special_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_special) |=> (out_data == $past(in_data) && out_be == $past(in_be)));

   // R5
   local_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_src && !in_ctl_hit) |=> (out_data == $past(in_data)));

   // R2
   host_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_src && in_mmio && !in_special && !in_ctl_hit && !flag)
      |=> (out_data[LANE_W-1:0] == $past(in_data[DATA_W-1 -: LANE_W])
           && out_be[0] == $past(in_be[LANES-1])));
endmodule

// File: tb/mmio_swap_bridge_tb.sv
module mmio_swap_bridge_tb;
   typedef struct {
      logic [31:0] d;
      logic [3:0]  be;
      string       tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_src = 1'b0, in_mmio = 1'b0, in_special = 1'b0;
   logic        in_ctl_hit = 1'b0, in_write = 1'b0;
   logic [31:0] in_data = '0;
   logic [3:0]  in_be = '0;
   logic        out_valid;
   logic [31:0] out_data;
   logic [3:0]  out_be;

   int    n_chk = 0, n_fail = 0;
   logic  mflag = 1'b0;
   item_t sb[$];
   logic [31:0] last_d;

   always #5 clk = ~clk;

   mmio_swap_bridge u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src(in_src),
      .in_mmio(in_mmio), .in_special(in_special), .in_ctl_hit(in_ctl_hit),
      .in_write(in_write), .in_data(in_data), .in_be(in_be),
      .out_valid(out_valid), .out_data(out_data), .out_be(out_be)
   );

   function automatic logic [31:0] rv(input logic [31:0] x);
      return {x[7:0], x[15:8], x[23:16], x[31:24]};
   endfunction

   task automatic check(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic src, input logic mmio, input logic spc, input logic ctl,
                        input logic wr, input logic [31:0] d, input logic [3:0] be, input string tag);
      item_t it;
      bit    sw;
      logic [31:0] base;
      @(negedge clk);
      in_valid = 1'b1; in_src = src; in_mmio = mmio; in_special = spc;
      in_ctl_hit = ctl; in_write = wr; in_data = d; in_be = be;
      sw   = mmio && !spc && !src && !mflag;
      base = (mmio && ctl && !spc && !wr) ? {31'b0, mflag} : d;
      it.d   = sw ? rv(base) : base;
      it.be  = sw ? {be[0], be[1], be[2], be[3]} : be;
      it.tag = tag;
      if (mmio && ctl && !spc && wr) mflag = it.d[0];
      last_d = it.d;
      sb.push_back(it);
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (sb.size() == 0) begin
            check(1'b0, "R11 unexpected output", {out_be, out_data}, 36'h0);
         end else begin
            item_t e;
            e = sb.pop_front();
            check(out_data == e.d && out_be == e.be, e.tag, {out_be, out_data}, {e.be, e.d});
         end
      end
   end

   initial begin
      repeat (1000) @(posedge clk);
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0 && out_data == '0 && out_be == '0, "R1 reset outputs",
            {out_be, out_data}, 36'h0);
      rst_n = 1'b1;
      // R2 R3 host write and read, flag clear
      drive(0, 1, 0, 0, 1, 32'h0102_0304, 4'b0011, "R2 R3 host write swapped");
      drive(0, 1, 0, 0, 0, 32'hAABB_CCDD, 4'b1111, "R2 host read swapped");
      drive(0, 1, 0, 0, 1, 32'h1234_5678, 4'b0100, "R3 be lane reversal");
      // R5 R6 R7 passes
      drive(1, 1, 0, 0, 1, 32'h1122_3344, 4'b0001, "R5 local mmio unswapped");
      drive(0, 0, 0, 0, 1, 32'h5566_7788, 4'b0011, "R6 non-mmio unswapped");
      drive(0, 1, 1, 1, 1, 32'h0100_0000, 4'b1000, "R7 special unswapped");
      drive(0, 1, 0, 1, 0, 32'hFFFF_FFFF, 4'b1111, "R1 R7 flag still clear after special");
      // R8 naive write position leaves flag clear
      drive(0, 1, 0, 1, 1, 32'h0000_0001, 4'b1111, "R8 naive ctl write");
      drive(1, 1, 0, 1, 0, 32'h0, 4'b1111, "R8 flag clear after naive write");
      // R8 R10 reversed position sets flag, back-to-back
      drive(0, 1, 0, 1, 1, 32'h0100_0000, 4'b1111, "R8 ctl write reversed position");
      drive(0, 1, 0, 0, 1, 32'h0102_0304, 4'b0011, "R10 R4 next access unswapped");
      drive(0, 1, 0, 1, 0, 32'h0, 4'b1111, "R9 host ctl read flag set");
      drive(1, 1, 0, 0, 0, 32'hCAFE_F00D, 4'b0110, "R5 local with flag set");
      drive(0, 0, 0, 0, 0, 32'hDEAD_BEEF, 4'b1000, "R6 non-mmio flag set");
      idle();
      @(negedge clk);
      check(out_valid == 1'b0 && out_data == last_d, "R11 idle hold", {4'h0, out_data}, {4'h0, last_d});
      // R10 local clears flag, host swaps again
      drive(1, 1, 0, 1, 1, 32'h0000_0000, 4'b1111, "R10 local ctl clear");
      drive(0, 1, 0, 0, 1, 32'hA1B2_C3D4, 4'b0001, "R10 R2 swap resumes");
      drive(0, 1, 0, 1, 0, 32'h0, 4'b1111, "R9 host ctl read flag clear");
      idle();
      repeat (3) @(negedge clk);
      check(sb.size() == 0, "R11 all results seen", 36'(sb.size()), 36'h0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule